// File: doc/BRIEF.md
# Subclock-to-Medium-Speed Direct Mode Transition Sequencer

This block moves a microcontroller from its slow run mode, clocked by the subclock, into the medium-speed active mode, clocked by the divided main oscillator. Software starts the move by executing a sleep instruction while five control bits hold one particular pattern. The block decodes those bits and lets the sleep and internal-processing states run out on the subclock. It then holds the chip in a watch state for a programmable oscillator settling wait. When that wait ends it switches the CPU clock selection, and it counts the interrupt exception handling states on the new clock.

The two clocks reach the block as single-cycle enable ticks on one fast clock. Subclock ticks time the phase before the switch and system-clock ticks time the phases after it. A 3-bit select field sets the settling wait as a power-of-two multiple of a base count, so the top setting gives 8192 states with the default base. Any other control pattern, and any sleep strobe outside the idle slow mode, leaves the block where it is.

Top module: `dtx_ctrl`

## Requirements
- R1: After reset the mode output is 00 (slow subclock run), clk_sel is 0 (subclock), and exc_req and done are 0.
- R2: A sleep strobe in idle slow mode starts a transition only when standby=1, low_speed=0, mid_speed=1, direct=1 and timer_b3=1. In the bench these bits form the index {standby,low_speed,mid_speed,direct,timer_b3}, and the qualifying index is 10111. For the other 31 patterns the mode stays 00 through the later subclock ticks.
- R3: After a qualifying strobe the mode stays 00 for SLEEP_STATES+INTPROC_STATES (default 2+1=3) subclock ticks and becomes 01 (watch) at the edge that takes the third tick. System-clock ticks have no effect in this phase.
- R4: The settling wait is loaded when watch is entered and lasts MIN_WAIT<<settle_sel system-clock ticks (64 to 8192 with the default MIN_WAIT=64). Subclock ticks have no effect during it.
- R5: At the edge that takes the last settling tick, the mode becomes 10 (medium-speed active) and clk_sel becomes 1 together. Before that edge clk_sel is 0.
- R6: At the edge that takes the EXC_STATES-th (default 14th) system-clock tick after the clock switch, exc_req rises for exactly one cycle. It pulses once per transition.
- R7: done pulses for one cycle in the cycle after exc_req. The block then stays in mode 10 with clk_sel 1.
- R8: A sleep strobe is ignored in every state other than idle slow mode, including the sleep, watch, exception and medium-speed phases. It neither restarts nor shortens any count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | One-cycle strobe from sleep instruction execution |
| standby | input | 1 | Standby-select control bit |
| low_speed | input | 1 | Low-speed-on control bit |
| mid_speed | input | 1 | Medium-speed-on control bit |
| direct | input | 1 | Direct-transition-on control bit |
| timer_b3 | input | 1 | Timer mode bit 3 |
| settle_sel | input | 3 | Oscillator settling time select |
| sub_tick | input | 1 | Subclock state enable tick |
| sys_tick | input | 1 | System-clock state enable tick |
| mode | output | 2 | Current mode: 00 slow, 01 watch, 10 medium, 11 high |
| clk_sel | output | 1 | CPU clock select: 0 subclock, 1 medium-speed clock |
| exc_req | output | 1 | One-cycle interrupt exception request |
| done | output | 1 | One-cycle transition-complete pulse |

## Verification
Every result is registered, so each output moves at the clock edge that takes the qualifying strobe or the deciding tick. The watch mode shows at the edge of the third subclock tick. The mode 10 and clk_sel changes show at the edge of the last settling tick, exc_req at the edge of the fourteenth tick after that, and done one edge later. The bench drives each tick or strobe for exactly one cycle from the falling edge and reads the outputs at the next falling edge. This places every check half a cycle after the edge where the result is due. One tick before each deadline it also confirms that the output has not yet moved. The bench sweeps all 32 control-bit patterns and all 8 settle selects with the wait lengths computed as 64<<sel.

// File: rtl/dtx_pkg.sv
package dtx_pkg;

    typedef enum logic [1:0] {
        MODE_SUB   = 2'b00,
        MODE_WATCH = 2'b01,
        MODE_MED   = 2'b10,
        MODE_HIGH  = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        PH_RUN,
        PH_SLEEP,
        PH_SETTLE,
        PH_EXC,
        PH_DONE
    } phase_e;

endpackage

// File: rtl/dtx_qualify.sv
module dtx_qualify (
    input  logic standby,
    input  logic low_speed,
    input  logic mid_speed,
    input  logic direct,
    input  logic timer_b3,
    output logic go_mid
);
    always_comb begin
        go_mid = standby & ~low_speed & mid_speed & direct & timer_b3;
    end
endmodule

// File: rtl/dtx_wait_table.sv
module dtx_wait_table #(
    parameter int MIN_WAIT = 64,
    parameter int SEL_W    = 3,
    parameter int CNT_W    = 14
) (
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] wait_len
);
    localparam logic [CNT_W-1:0] BASE = CNT_W'(MIN_WAIT);

    always_comb begin
        wait_len = BASE << sel;
    end
endmodule

// File: rtl/dtx_ctrl.sv
module dtx_ctrl
    import dtx_pkg::*;
#(
    parameter int MIN_WAIT       = 64,
    parameter int SEL_W          = 3,
    parameter int SLEEP_STATES   = 2,
    parameter int INTPROC_STATES = 1,
    parameter int EXC_STATES     = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             standby,
    input  logic             low_speed,
    input  logic             mid_speed,
    input  logic             direct,
    input  logic             timer_b3,
    input  logic [SEL_W-1:0] settle_sel,
    input  logic             sub_tick,
    input  logic             sys_tick,
    output logic [1:0]       mode,
    output logic             clk_sel,
    output logic             exc_req,
    output logic             done
);
    localparam int MAX_WAIT  = MIN_WAIT << ((1 << SEL_W) - 1);
    localparam int CNT_W     = $clog2(MAX_WAIT + 1);
    localparam int SUB_PHASE = SLEEP_STATES + INTPROC_STATES;
    localparam logic [CNT_W-1:0] SUB_LOAD = CNT_W'(SUB_PHASE);
    localparam logic [CNT_W-1:0] EXC_LOAD = CNT_W'(EXC_STATES);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    typedef struct packed {
        phase_e           phase;
        mode_e            mode;
        logic [CNT_W-1:0] cnt;
        logic             clk_sel;
        logic             exc;
        logic             done;
    } state_t;

    state_t st_d, st_q;
    logic   go_mid;
    logic [CNT_W-1:0] wait_len;

    dtx_qualify u_qual (
        .standby  (standby),
        .low_speed(low_speed),
        .mid_speed(mid_speed),
        .direct   (direct),
        .timer_b3 (timer_b3),
        .go_mid   (go_mid)
    );

    dtx_wait_table #(
        .MIN_WAIT(MIN_WAIT),
        .SEL_W   (SEL_W),
        .CNT_W   (CNT_W)
    ) u_wait (
        .sel     (settle_sel),
        .wait_len(wait_len)
    );

    always_comb begin
        st_d      = st_q;
        st_d.exc  = 1'b0;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_RUN: begin
                if (sleep_req && st_q.mode == MODE_SUB && go_mid) begin
                    st_d.phase = PH_SLEEP;
                    st_d.cnt   = SUB_LOAD;
                end
            end
            PH_SLEEP: begin
                if (sub_tick) begin
                    if (st_q.cnt == ONE) begin
                        st_d.phase = PH_SETTLE;
                        st_d.mode  = MODE_WATCH;
                        st_d.cnt   = wait_len;
                    end else begin
                        st_d.cnt = st_q.cnt - ONE;
                    end
                end
            end
            PH_SETTLE: begin
                if (sys_tick) begin
                    if (st_q.cnt == ONE) begin
                        st_d.phase   = PH_EXC;
                        st_d.mode    = MODE_MED;
                        st_d.clk_sel = 1'b1;
                        st_d.cnt     = EXC_LOAD;
                    end else begin
                        st_d.cnt = st_q.cnt - ONE;
                    end
                end
            end
            PH_EXC: begin
                if (sys_tick) begin
                    if (st_q.cnt == ONE) begin
                        st_d.phase = PH_DONE;
                        st_d.exc   = 1'b1;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt - ONE;
                    end
                end
            end
            PH_DONE: begin
                st_d.phase = PH_RUN;
                st_d.done  = 1'b1;
            end
            default: begin
                st_d.phase = PH_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase   <= PH_RUN;
            st_q.mode    <= MODE_SUB;
            st_q.cnt     <= '0;
            st_q.clk_sel <= 1'b0;
            st_q.exc     <= 1'b0;
            st_q.done    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode    = st_q.mode;
    assign clk_sel = st_q.clk_sel;
    assign exc_req = st_q.exc;
    assign done    = st_q.done;

endmodule

// File: rtl/dtx_ctrl_chk.sv
module dtx_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       clk_sel,
    input logic       exc_req,
    input logic       done
);
    AST_WATCH_FROM_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && $past(mode) != 2'b01) |-> $past(mode) == 2'b00); // R3

    AST_MED_FROM_WATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && $past(mode) != 2'b10) |-> $past(mode) == 2'b01); // R5

    AST_CLKSEL_WITH_MED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_sel) |-> (mode == 2'b10 && $past(mode) == 2'b01)); // R5

    AST_CLKSEL_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 || mode == 2'b01) |-> !clk_sel); // R5

    AST_EXC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> !exc_req); // R6

    AST_EXC_ON_FAST_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> (clk_sel && mode == 2'b10)); // R6

    AST_DONE_AFTER_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(exc_req)); // R7

    AST_STAY_MED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode) == 2'b10 |-> (mode == 2'b10 && clk_sel)); // R7
endmodule

bind dtx_ctrl dtx_ctrl_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode),
    .clk_sel(clk_sel),
    .exc_req(exc_req),
    .done   (done)
);

// File: tb/tb_dtx_ctrl.sv
module tb_dtx_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0;
    logic       standby = 1'b0, low_speed = 1'b0, mid_speed = 1'b0;
    logic       direct = 1'b0, timer_b3 = 1'b0;
    logic [2:0] settle_sel = 3'd0;
    logic       sub_tick = 1'b0, sys_tick = 1'b0;
    logic [1:0] mode;
    logic       clk_sel, exc_req, done;

    int checks = 0;
    int failures = 0;
    int exc_cnt = 0;
    int cycles = 0;

    dtx_ctrl dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
        .standby(standby), .low_speed(low_speed), .mid_speed(mid_speed),
        .direct(direct), .timer_b3(timer_b3), .settle_sel(settle_sel),
        .sub_tick(sub_tick), .sys_tick(sys_tick),
        .mode(mode), .clk_sel(clk_sel), .exc_req(exc_req), .done(done)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (exc_req) exc_cnt <= exc_cnt + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_bits(input logic [4:0] c);
        {standby, low_speed, mid_speed, direct, timer_b3} = c;
    endtask

    task automatic pulse_sleep();
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
    endtask

    task automatic pulse_sub(input int n);
        for (int i = 0; i < n; i++) begin
            sub_tick = 1'b1;
            @(negedge clk);
            sub_tick = 1'b0;
        end
    endtask

    task automatic pulse_sys(input int n);
        for (int i = 0; i < n; i++) begin
            sys_tick = 1'b1;
            @(negedge clk);
            sys_tick = 1'b0;
        end
    endtask

    task automatic full_run(input int sel);
        int wlen;
        int exc0;
        wlen = 64 << sel;
        settle_sel = 3'(sel);
        do_reset();
        set_bits(5'b10111);
        pulse_sleep();
        check("R3 mode held after strobe", mode, 0);
        pulse_sys(3);
        check("R3 sys ticks ignored in sleep phase", mode, 0);
        pulse_sub(2);
        check("R3 mode before third sub tick", mode, 0);
        pulse_sleep();
        pulse_sub(1);
        check("R3 watch on third sub tick (R8 strobe ignored)", mode, 1);
        check("R5 clk_sel still subclock in watch", clk_sel, 0);
        pulse_sub(4);
        pulse_sleep();
        pulse_sys(wlen - 1);
        check("R4 still watch one tick before end", mode, 1);
        check("R5 clk_sel low before last settle tick", clk_sel, 0);
        pulse_sys(1);
        check("R4 R5 mode medium at last settle tick", mode, 2);
        check("R5 clk_sel switches with mode", clk_sel, 1);
        exc0 = exc_cnt;
        pulse_sleep();
        pulse_sys(13);
        check("R6 no exc before 14th tick", exc_req, 0);
        pulse_sys(1);
        check("R6 exc_req at 14th tick", exc_req, 1);
        check("R7 done not with exc", done, 0);
        @(negedge clk);
        check("R6 exc_req one cycle", exc_req, 0);
        check("R7 done after exc", done, 1);
        @(negedge clk);
        check("R7 done one cycle", done, 0);
        set_bits(5'b10111);
        pulse_sleep();
        pulse_sub(5);
        pulse_sys(20);
        check("R8 strobe in medium ignored", mode, 2);
        check("R7 clk_sel stays fast", clk_sel, 1);
        check("R6 single exc per transition", exc_cnt - exc0, 1);
    endtask

    initial begin
        do_reset();
        check("R1 reset mode", mode, 0);
        check("R1 reset clk_sel", clk_sel, 0);
        check("R1 reset exc_req", exc_req, 0);
        check("R1 reset done", done, 0);

        for (int c = 0; c < 32; c++) begin
            settle_sel = 3'd0;
            do_reset();
            set_bits(5'(c));
            pulse_sleep();
            pulse_sub(3);
            check($sformatf("R2 pattern %0d", c), mode, (c == 5'b10111) ? 1 : 0);
        end

        for (int s = 0; s < 8; s++) full_run(s);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule